// File: doc/BRIEF.md
# Streaming Equi-Join Merge Unit

This block joins two relations that arrive already ordered on a 32-bit join key. The inner relation is streamed in first and kept in a small local buffer. The outer relation is then streamed past it. Every pair of tuples whose keys match leaves the block as a triple: the key, the outer payload and the inner payload.

The unit walks both relations together. When the outer key is smaller, it retires the outer tuple. When the inner key is smaller, it steps the inner read position. When the keys match, it emits a pair and steps the inner position.

The first matching inner position of a key group is remembered. When the next outer tuple carries the same key, the inner position jumps back to that mark. In this way a run of repeated outer keys meets the whole inner group each time, while each outer tuple is taken exactly once. Results go to a private output register with a valid/ready handshake, so no coordination with other units is needed. One join runs per reset.

Top module: `sortmerge_join`

## Requirements
- R1: After reset the unit is in its load phase. In this phase inner_ready is high, outer_ready is low, and each accepted inner tuple is stored in arrival order. The load phase ends when an inner tuple with inner_last=1 is accepted.
- R2: The load phase also ends as soon as DEPTH inner tuples are stored. inner_ready then stays low, and later inner tuples are neither accepted nor ever matched.
- R3: Every (outer, inner) pair whose keys are equal appears exactly once on the match port, with keys compared as unsigned 32-bit values. Pairs are ordered first by outer arrival and then by inner arrival. Each pair carries the key, the outer payload and the inner payload.
- R4: Consecutive outer tuples with the same key each meet the complete inner group of that key. A key therefore yields (outer count × inner count) pairs.
- R5: Each outer tuple is accepted at most once, and outer_ready is low in the cycle after an outer tuple is accepted.
- R6: While match_valid is high and match_ready is low, match_valid stays high and all match fields stay stable. Backpressure loses no pair and duplicates none.
- R7: join_done rises once the outer tuple flagged outer_last has been retired. It stays high until reset, and outer_ready is low while it is high.
- R8: join_done also rises when the inner read position has passed the last stored tuple while no equal-key group is open. Remaining outer tuples are then left unconsumed.
- R9: During and right after reset: match_valid=0, join_done=0, inner_ready=1 and outer_ready=0.
- R10: Keys on accepted match transfers never decrease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inner_valid | input | 1 | Inner tuple offered |
| inner_ready | output | 1 | Inner tuple can be taken (load phase) |
| inner_key | input | 32 | Inner join key |
| inner_pay | input | 32 | Inner payload |
| inner_last | input | 1 | Final inner tuple |
| outer_valid | input | 1 | Outer tuple offered |
| outer_ready | output | 1 | Outer tuple can be taken |
| outer_key | input | 32 | Outer join key |
| outer_pay | input | 32 | Outer payload |
| outer_last | input | 1 | Final outer tuple |
| match_valid | output | 1 | Match triple present |
| match_ready | input | 1 | Downstream takes the match |
| match_key | output | 32 | Shared key of the pair |
| match_outer_pay | output | 32 | Outer payload of the pair |
| match_inner_pay | output | 32 | Inner payload of the pair |
| join_done | output | 1 | Join finished |

## Verification
Two functions can fall in the same cycle: the downstream taking a match out of the output register, and the walker placing the next match into that register. This happens inside dense duplicate groups with match_ready held high, where every cycle both drains and refills the register. Irregular match_ready patterns then mix those cycles with stalls.

Both are judged by comparing the ordered list of received triples against a list the bench builds by nested loops over the sorted inputs. The bench also checks that every stalled triple is unchanged one cycle later. The sweep covers all small outer/inner lengths with several key patterns, plus cases for a full buffer, early exhaustion and early outer end.

// File: rtl/smj_pkg.sv
// Shared widths and record types for the sort-merge join unit.
package smj_pkg;
    parameter int unsigned KEY_W = 32;
    parameter int unsigned PAY_W = 32;

    typedef logic [KEY_W-1:0] key_t;
    typedef logic [PAY_W-1:0] pay_t;

    // One tuple of either relation.
    typedef struct packed {
        key_t key;
        pay_t pay;
    } tup_t;

    // One produced join pair.
    typedef struct packed {
        key_t key;
        pay_t r_pay;
        pay_t s_pay;
    } hit_t;
endpackage

// File: rtl/smj_inner_buf.sv
// Inner relation store: appends tuples in arrival order and offers an
// asynchronous read at any index. Assumes the writer never exceeds DEPTH
// entries; an index at or beyond DEPTH reads as zero.
module smj_inner_buf
    import smj_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  tup_t          wr_tup,
    input  logic [CW-1:0] rd_idx,
    output tup_t          rd_tup,
    output logic [CW-1:0] fill
);
    tup_t mem [DEPTH];

    // Store an accepted tuple at the current fill position.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[fill[AW-1:0]] <= wr_tup;
        end
    end

    // Count stored tuples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill <= '0;
        end else if (wr_en) begin
            fill <= fill + 1'b1;
        end
    end

    // Read port with a guard against out-of-range indices.
    always_comb begin
        rd_tup = (rd_idx < CW'(DEPTH)) ? mem[rd_idx[AW-1:0]] : '0;
    end
endmodule

// File: rtl/smj_walker.sv
// Join control: owns the load/join phasing, the held outer tuple, the inner
// read index, the group mark used for rewind, and completion. Assumes both
// relations arrive sorted ascending by unsigned key. Every join step waits
// for room in the output register, so backpressure freezes all pointers.
module smj_walker
    import smj_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_fire,
    input  logic          s_last,
    input  logic [CW-1:0] fill,
    output logic          loading,
    input  logic          r_valid,
    input  tup_t          r_tup,
    input  logic          r_last,
    output logic          r_ready,
    output logic [CW-1:0] s_rd_idx,
    input  tup_t          s_rd_tup,
    input  logic          hit_room,
    output logic          hit_push,
    output hit_t          hit,
    output logic          done
);
    logic          held;
    tup_t          h_tup;
    logic          h_last;
    logic [CW-1:0] idx;
    logic [CW-1:0] mark;
    logic          grp_v;
    key_t          grp_key;

    logic s_end, k_eq, k_lt, step, r_fire, exhaust, same_grp;

    // Compare decode and step enables for the current position.
    always_comb begin
        s_end    = (idx >= fill);
        k_eq     = !s_end && (h_tup.key == s_rd_tup.key);
        k_lt     = s_end || (h_tup.key < s_rd_tup.key);
        r_ready  = !loading && !done && !held;
        r_fire   = r_valid && r_ready;
        step     = !loading && !done && held && hit_room;
        hit_push = step && k_eq;
        exhaust  = !loading && !done && s_end && !grp_v;
        same_grp = grp_v && (grp_key == h_tup.key);
        s_rd_idx = idx;
        hit      = '{key: h_tup.key, r_pay: h_tup.pay, s_pay: s_rd_tup.pay};
    end

    // Load-phase exit: last inner tuple accepted or buffer filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loading <= 1'b1;
        end else if (loading && s_fire && (s_last || fill == CW'(DEPTH - 1))) begin
            loading <= 1'b0;
        end
    end

    // Outer holding register, inner index, group mark and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held    <= 1'b0;
            h_tup   <= '0;
            h_last  <= 1'b0;
            idx     <= '0;
            mark    <= '0;
            grp_v   <= 1'b0;
            grp_key <= '0;
            done    <= 1'b0;
        end else begin
            if (r_fire) begin
                held   <= 1'b1;
                h_tup  <= r_tup;
                h_last <= r_last;
                if (grp_v && (r_tup.key == grp_key)) begin
                    idx <= mark;
                end else begin
                    grp_v <= 1'b0;
                end
            end
            if (step) begin
                if (k_eq) begin
                    if (!same_grp) begin
                        mark    <= idx;
                        grp_key <= h_tup.key;
                        grp_v   <= 1'b1;
                    end
                    idx <= idx + 1'b1;
                end else if (k_lt) begin
                    held <= 1'b0;
                    if (h_last) begin
                        done <= 1'b1;
                    end
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            if (exhaust) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/smj_out_reg.sv
// Single-entry output register with a valid/ready handshake. It takes a new
// entry whenever it is empty or being drained in the same cycle.
module smj_out_reg
    import smj_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  hit_t din,
    output logic room,
    output logic o_valid,
    input  logic o_ready,
    output hit_t o_data
);
    // Free when empty or emptying this cycle.
    always_comb begin
        room = !o_valid || o_ready;
    end

    // Capture or drain the held entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_data  <= '0;
        end else if (room) begin
            o_valid <= push;
            if (push) begin
                o_data <= din;
            end
        end
    end
endmodule

// File: rtl/sortmerge_join.sv
// Streaming equi-join of two key-sorted relations. The inner relation is
// loaded first into a local buffer of DEPTH entries, then the outer stream
// is merged against it with rewind over duplicate key groups. Assumes
// ascending unsigned key order on both inputs. One join per reset.
module sortmerge_join
    import smj_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inner_valid,
    output logic             inner_ready,
    input  logic [KEY_W-1:0] inner_key,
    input  logic [PAY_W-1:0] inner_pay,
    input  logic             inner_last,
    input  logic             outer_valid,
    output logic             outer_ready,
    input  logic [KEY_W-1:0] outer_key,
    input  logic [PAY_W-1:0] outer_pay,
    input  logic             outer_last,
    output logic             match_valid,
    input  logic             match_ready,
    output logic [KEY_W-1:0] match_key,
    output logic [PAY_W-1:0] match_outer_pay,
    output logic [PAY_W-1:0] match_inner_pay,
    output logic             join_done
);
    logic          s_fire, loading, hit_push, hit_room;
    logic [CW-1:0] fill_cnt, rd_idx;
    tup_t          rd_tup;
    hit_t          hit, out_q;

    // Inner handshake follows the load phase.
    always_comb begin
        inner_ready = loading;
        s_fire      = inner_valid && inner_ready;
    end

    smj_inner_buf #(.DEPTH(DEPTH)) buf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (s_fire),
        .wr_tup ('{key: inner_key, pay: inner_pay}),
        .rd_idx (rd_idx),
        .rd_tup (rd_tup),
        .fill   (fill_cnt)
    );

    smj_walker #(.DEPTH(DEPTH)) walk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_fire   (s_fire),
        .s_last   (inner_last),
        .fill     (fill_cnt),
        .loading  (loading),
        .r_valid  (outer_valid),
        .r_tup    ('{key: outer_key, pay: outer_pay}),
        .r_last   (outer_last),
        .r_ready  (outer_ready),
        .s_rd_idx (rd_idx),
        .s_rd_tup (rd_tup),
        .hit_room (hit_room),
        .hit_push (hit_push),
        .hit      (hit),
        .done     (join_done)
    );

    smj_out_reg out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (hit_push),
        .din     (hit),
        .room    (hit_room),
        .o_valid (match_valid),
        .o_ready (match_ready),
        .o_data  (out_q)
    );

    // Unpack the output record onto the ports.
    always_comb begin
        match_key       = out_q.key;
        match_outer_pay = out_q.r_pay;
        match_inner_pay = out_q.s_pay;
    end
endmodule

// File: rtl/smj_join_chk.sv
// Property checker for sortmerge_join, attached by bind.
module smj_join_chk
    import smj_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inner_ready,
    input logic             outer_valid,
    input logic             outer_ready,
    input logic             match_valid,
    input logic             match_ready,
    input logic [KEY_W-1:0] match_key,
    input logic [PAY_W-1:0] match_outer_pay,
    input logic [PAY_W-1:0] match_inner_pay,
    input logic             join_done,
    input logic [CW-1:0]    fill_cnt
);
    a_r1_no_outer_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        inner_ready |-> !outer_ready);

    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

    a_r2_full_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt == CW'(DEPTH)) |-> !inner_ready);

    a_r5_take_once: assert property (@(posedge clk) disable iff (!rst_n)
        (outer_valid && outer_ready) |=> !outer_ready);

    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid && !match_ready) |=> (match_valid && $stable(match_key)
            && $stable(match_outer_pay) && $stable(match_inner_pay)));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        join_done |=> join_done);

    a_r7_done_blocks_outer: assert property (@(posedge clk) disable iff (!rst_n)
        join_done |-> !outer_ready);

    a_r10_key_order: assert property (@(posedge clk) disable iff (!rst_n)
        (match_valid && match_ready) |=> (!match_valid || match_key >= $past(match_key)));
endmodule

bind sortmerge_join smj_join_chk #(.DEPTH(DEPTH)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .inner_ready     (inner_ready),
    .outer_valid     (outer_valid),
    .outer_ready     (outer_ready),
    .match_valid     (match_valid),
    .match_ready     (match_ready),
    .match_key       (match_key),
    .match_outer_pay (match_outer_pay),
    .match_inner_pay (match_inner_pay),
    .join_done       (join_done),
    .fill_cnt        (fill_cnt)
);

// File: tb/sortmerge_join_tb_top.sv
`timescale 1ns/1ps
module sortmerge_join_tb_top;
    localparam int BD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inner_valid = 1'b0, inner_last = 1'b0;
    logic [31:0] inner_key = '0, inner_pay = '0;
    logic        outer_valid = 1'b0, outer_last = 1'b0;
    logic [31:0] outer_key = '0, outer_pay = '0;
    logic        match_ready = 1'b0;
    logic        inner_ready, outer_ready, match_valid, join_done;
    logic [31:0] match_key, match_outer_pay, match_inner_pay;

    int total = 0, bad = 0, cyc = 0;
    int nr, ns, n_exp, got, s_acc, r_acc;
    bit bp;
    logic [31:0] rk [16];
    logic [31:0] sk [16];
    logic [31:0] e_key [256];
    logic [31:0] e_rp [256];
    logic [31:0] e_sp [256];

    sortmerge_join #(.DEPTH(BD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .inner_valid(inner_valid), .inner_ready(inner_ready), .inner_key(inner_key),
        .inner_pay(inner_pay), .inner_last(inner_last),
        .outer_valid(outer_valid), .outer_ready(outer_ready), .outer_key(outer_key),
        .outer_pay(outer_pay), .outer_last(outer_last),
        .match_valid(match_valid), .match_ready(match_ready), .match_key(match_key),
        .match_outer_pay(match_outer_pay), .match_inner_pay(match_inner_pay),
        .join_done(join_done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    // Watchdog: a hung run is one failed check and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Reference pairs from nested loops over the sorted inputs (R2, R3, R4).
    task automatic build_exp();
        int ns_eff = (ns < BD) ? ns : BD;
        n_exp = 0;
        for (int i = 0; i < nr; i++)
            for (int j = 0; j < ns_eff; j++)
                if (rk[i] == sk[j]) begin
                    e_key[n_exp] = rk[i];
                    e_rp[n_exp]  = 32'h1000 + i;
                    e_sp[n_exp]  = 32'h2000 + j;
                    n_exp++;
                end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        inner_valid = 1'b0;
        outer_valid = 1'b0;
        match_ready = 1'b0;
        repeat (2) @(negedge clk);
        check(match_valid == 1'b0 && join_done == 1'b0, "R9 reset outputs",
              {match_valid, join_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(inner_ready == 1'b1 && outer_ready == 1'b0, "R9 R1 after reset",
              {inner_ready, outer_ready}, 2);
    endtask

    task automatic feed_inner();
        s_acc = 0;
        for (int j = 0; j < ns; j++) begin
            bit took = 0;
            @(negedge clk);
            inner_valid = 1'b1;
            inner_key   = sk[j];
            inner_pay   = 32'h2000 + j;
            inner_last  = (j == ns - 1);
            for (int w = 0; w < 20 && !took; w++) begin
                #1;
                if (inner_ready) begin
                    @(posedge clk);
                    took = 1;
                    s_acc++;
                end else begin
                    @(negedge clk);
                end
            end
            if (!took) break;
        end
        @(negedge clk);
        inner_valid = 1'b0;
    endtask

    task automatic feed_outer();
        bit stop = 0;
        r_acc = 0;
        for (int i = 0; i < nr && !stop; i++) begin
            bit took = 0;
            @(negedge clk);
            outer_valid = 1'b1;
            outer_key   = rk[i];
            outer_pay   = 32'h1000 + i;
            outer_last  = (i == nr - 1);
            while (!took && !stop) begin
                #1;
                if (join_done) begin
                    stop = 1;
                end else if (outer_ready) begin
                    @(posedge clk);
                    took = 1;
                    r_acc++;
                end else begin
                    @(negedge clk);
                end
            end
        end
        @(negedge clk);
        outer_valid = 1'b0;
    endtask

    task automatic sink();
        bit hold_v = 0;
        logic [31:0] hk = '0, hr = '0, hs = '0, last_k = '0;
        bit have_last = 0;
        got = 0;
        while (1) begin
            @(negedge clk);
            match_ready = bp ? (((cyc * 3 + nr + ns) % 4) != 0 && (cyc % 7) != 3) : 1'b1;
            #1;
            if (hold_v) begin
                check(match_valid && match_key == hk && match_outer_pay == hr && match_inner_pay == hs,
                      "R6 stalled triple held", match_outer_pay, hr);
                hold_v = 0;
            end
            if (match_valid) begin
                if (match_ready) begin
                    if (got < n_exp) begin
                        check(match_key == e_key[got], "R3 match key", match_key, e_key[got]);
                        check(match_outer_pay == e_rp[got] && match_inner_pay == e_sp[got],
                              "R4 pair payloads", {match_outer_pay[15:0], match_inner_pay[15:0]},
                              {e_rp[got][15:0], e_sp[got][15:0]});
                    end else begin
                        check(0, "R3 extra match", got + 1, n_exp);
                    end
                    if (have_last)
                        check(match_key >= last_k, "R10 key order", match_key, last_k);
                    last_k = match_key;
                    have_last = 1;
                    got++;
                end else begin
                    hold_v = 1;
                    hk = match_key;
                    hr = match_outer_pay;
                    hs = match_inner_pay;
                end
            end
            if (join_done && !match_valid) break;
        end
    endtask

    task automatic run_case();
        build_exp();
        do_reset();
        fork
            feed_inner();
            feed_outer();
            sink();
        join
        check(got == n_exp, "R3 match count", got, n_exp);
        check(join_done == 1'b1, "R7 R8 done", join_done, 1);
        check(outer_ready == 1'b0, "R7 outer closed after done", outer_ready, 0);
        check(r_acc <= nr, "R5 outer taken once", r_acc, nr);
        check(s_acc == ((ns < BD) ? ns : BD), "R1 R2 inner accepted", s_acc, (ns < BD) ? ns : BD);
    endtask

    initial begin
        // Sweep of small lengths and key patterns.
        for (int a = 1; a <= 5; a++)
            for (int b = 1; b <= 5; b++)
                for (int v = 0; v < 4; v++) begin
                    nr = a;
                    ns = b;
                    bp = v[0];
                    rk[0] = v % 2;
                    sk[0] = (v >> 1);
                    for (int i = 1; i < nr; i++)
                        rk[i] = rk[i-1] + (((i * 3 + v + a) % 3) == 0 ? 1 : 0);
                    for (int j = 1; j < ns; j++)
                        sk[j] = sk[j-1] + (((j * 5 + v + b) % 4) < 2 ? 1 : 0);
                    run_case();
                end

        // R4: all keys equal, 3 x 4 pairs.
        nr = 3; ns = 4; bp = 1;
        for (int i = 0; i < 3; i++) rk[i] = 2;
        for (int j = 0; j < 4; j++) sk[j] = 2;
        run_case();
        check(n_exp == 12 && got == 12, "R4 many-to-many count", got, 12);

        // R2: inner longer than the buffer; only the first BD entries join.
        nr = 4; ns = 11; bp = 0;
        for (int j = 0; j < 11; j++) sk[j] = j;
        rk[0] = 0; rk[1] = 3; rk[2] = 7; rk[3] = 9;
        run_case();
        check(got == 3, "R2 overflow tuples not matched", got, 3);

        // R8: inner exhausted with outer left over.
        nr = 4; ns = 2; bp = 0;
        sk[0] = 1; sk[1] = 2;
        rk[0] = 1; rk[1] = 5; rk[2] = 6; rk[3] = 7;
        run_case();
        check(r_acc == 2, "R8 outer left unconsumed", r_acc, 2);

        // R7: outer ends before inner is used up.
        nr = 1; ns = 4; bp = 1;
        for (int j = 0; j < 4; j++) sk[j] = j + 1;
        rk[0] = 1;
        run_case();
        check(r_acc == 1 && got == 1, "R7 done on outer last", r_acc, 1);

        // R4: group at inner end with repeated outer keys (rewind after exhaustion).
        nr = 3; ns = 1; bp = 1;
        sk[0] = 3;
        for (int i = 0; i < 3; i++) rk[i] = 3;
        run_case();
        check(got == 3, "R4 rewind at inner end", got, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule